// File: doc/BRIEF.md
# Infrared Pulse Shaper

This block sits between a UART and an external infrared transceiver. On the transmit side it watches the UART's NRZ output. For every zero bit it fires one short fixed-width pulse on the LED drive. The pulse width is a parameter counted in system clocks and set to the nominal width of the fastest bit rate: 1.6 µs, which is 3/16 of a bit at 115200 bit/s. The LED drive is off at all other times.

On the receive side the transceiver delivers an active-low pulse for each zero bit. The block synchronises that line to the system clock. On each leading edge it holds the UART receive input low for one full bit time. The bit time is also a parameter counted in clocks. The result is an NRZ waveform that the UART can sample.

A bit-boundary tick from the baud generator lets the transmit side emit one pulse per bit when several zero bits follow each other. Two resets clear the block: a global synchronous reset and a soft reset bit driven from a control register. Either one turns the LED off and drives the receive output high.

Top module: `ir_pulse_shaper`

## Requirements
- R1: While `rst` or `soft_rst` is high at a clock edge, `ir_led` is 0 and `uart_rxd` is 1 after that edge.
- R2: A falling edge on `uart_txd` drives `ir_led` high from the next clock edge for exactly TX_PULSE_CLKS clock cycles.
- R3: `ir_led` is never high except inside a pulse started by a zero bit. An idle-high `uart_txd` produces no pulse, even while `bit_tick` keeps arriving.
- R4: The UART updates `uart_txd` in the cycle after `bit_tick`. If `uart_txd` is low in that cycle, a new pulse starts. N zero bits in a row therefore give N pulses, and a frame carries one pulse per zero bit.
- R5: `ir_rxd_n` is active low. After the first clock edge that samples it low, `uart_rxd` goes low two edges later. Counting the cycles sampled between edges, it goes low on the third.
- R6: Once low, `uart_rxd` stays low for exactly RX_BIT_CLKS cycles. The width of the incoming pulse has no effect, even when the pulse lasts longer than the bit time.
- R7: A new leading edge on `ir_rxd_n` during a stretched bit restarts the RX_BIT_CLKS window.
- R8: On leaving reset, a line that was already low (`uart_txd` or `ir_rxd_n`) produces no pulse and no stretched bit.
- R9: Asserting `soft_rst` in the middle of a transmit pulse ends that pulse at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Global synchronous reset, active high |
| soft_rst | input | 1 | Soft reset bit from a control register, active high |
| uart_txd | input | 1 | NRZ transmit data from the UART, idle high |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary from the baud generator |
| ir_rxd_n | input | 1 | Receive pulses from the transceiver, active low, asynchronous |
| ir_led | output | 1 | LED drive to the transceiver, 1 turns the LED on |
| uart_rxd | output | 1 | Stretched NRZ receive data to the UART |

## Verification
A transmit counter with the wrong value shows up at `ir_led` within one pulse. The pulse is too long or too short, or it fails to end, so the LED stays lit. A stale edge-detect register shows up as a missing or spurious pulse at the next bit boundary, or as a pulse just after reset is released. On the receive side, faults in the synchroniser or the stretch counter change when `uart_rxd` falls or how long it stays low. This is visible within one bit time of the incoming pulse. A restart fault shows only when a second pulse arrives while a bit is still being stretched.

// File: rtl/irps_pkg.sv
package irps_pkg;
  // Width of a down-counter that must hold values 0 .. n-1.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irps_sync.sv
module irps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (clr) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irps_tx_narrow.sv
module irps_tx_narrow
  import irps_pkg::*;
#(
  parameter int TX_PULSE_CLKS = 80
) (
  input  logic clk,
  input  logic clr,
  input  logic uart_txd,
  input  logic bit_tick,
  output logic led
);
  localparam int CW = cnt_width(TX_PULSE_CLKS);
  localparam logic [CW-1:0] LOAD = CW'(TX_PULSE_CLKS - 1);

  logic          txd_q;
  logic          tick_q;
  logic [CW-1:0] cnt;
  logic          start;

  // Zero bit begins on a falling edge or at a bit boundary with the line low.
  assign start = !uart_txd && (txd_q || tick_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      txd_q  <= 1'b0;
      tick_q <= 1'b0;
      cnt    <= '0;
      led    <= 1'b0;
    end else begin
      txd_q  <= uart_txd;
      tick_q <= bit_tick;
      if (start) begin
        led <= 1'b1;
        cnt <= LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        led <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irps_rx_stretch.sv
module irps_rx_stretch
  import irps_pkg::*;
#(
  parameter int RX_BIT_CLKS = 434
) (
  input  logic clk,
  input  logic clr,
  input  logic rx_sync,
  output logic rxd
);
  localparam int CW = cnt_width(RX_BIT_CLKS);
  localparam logic [CW-1:0] LOAD = CW'(RX_BIT_CLKS - 1);

  logic          prev;
  logic [CW-1:0] cnt;
  logic          lead;

  assign lead = prev && !rx_sync;

  always_ff @(posedge clk) begin
    if (clr) begin
      prev <= 1'b0;
      cnt  <= '0;
      rxd  <= 1'b1;
    end else begin
      prev <= rx_sync;
      if (lead) begin
        rxd <= 1'b0;
        cnt <= LOAD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        rxd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_pulse_shaper.sv
module ir_pulse_shaper #(
  parameter int TX_PULSE_CLKS = 80,
  parameter int RX_BIT_CLKS   = 434,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic uart_txd,
  input  logic bit_tick,
  input  logic ir_rxd_n,
  output logic ir_led,
  output logic uart_rxd
);
  logic clr;
  logic rx_s;

  assign clr = rst || soft_rst;

  irps_tx_narrow #(.TX_PULSE_CLKS(TX_PULSE_CLKS)) u_tx (
    .clk(clk), .clr(clr), .uart_txd(uart_txd), .bit_tick(bit_tick), .led(ir_led)
  );

  irps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr(clr), .d(ir_rxd_n), .q(rx_s)
  );

  irps_rx_stretch #(.RX_BIT_CLKS(RX_BIT_CLKS)) u_rx (
    .clk(clk), .clr(clr), .rx_sync(rx_s), .rxd(uart_rxd)
  );
endmodule

// File: rtl/ir_pulse_shaper_chk.sv
module ir_pulse_shaper_chk #(
  parameter int TX_PULSE_CLKS = 80
) (
  input logic clk,
  input logic rst,
  input logic soft_rst,
  input logic uart_txd,
  input logic ir_rxd_n,
  input logic ir_led,
  input logic uart_rxd
);
  logic [31:0] led_run;

  always_ff @(posedge clk) begin
    if (rst || !ir_led) led_run <= '0;
    else                led_run <= led_run + 1;
  end

  assert_reset_led_off_R1: assert property (@(posedge clk)
    (rst || soft_rst) |=> !ir_led);

  assert_reset_rxd_high_R1: assert property (@(posedge clk)
    (rst || soft_rst) |=> uart_rxd);

  assert_led_width_R2: assert property (@(posedge clk) disable iff (rst)
    led_run <= 32'(TX_PULSE_CLKS));

  assert_led_needs_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_led) |-> !$past(uart_txd));

  assert_rx_fall_source_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $fell(uart_rxd) |-> !$past(ir_rxd_n, 2));
endmodule

bind ir_pulse_shaper ir_pulse_shaper_chk #(.TX_PULSE_CLKS(TX_PULSE_CLKS)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .uart_txd(uart_txd),
  .ir_rxd_n(ir_rxd_n), .ir_led(ir_led), .uart_rxd(uart_rxd)
);

// File: tb/ir_pulse_shaper_bench.sv
module ir_pulse_shaper_bench;
  localparam int TXP = 5;
  localparam int RXB = 16;
  localparam int BIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic uart_txd = 1'b1;
  logic bit_tick = 1'b0;
  logic ir_rxd_n = 1'b1;
  logic ir_led;
  logic uart_rxd;

  int tests = 0;
  int fails = 0;

  int led_pulses = 0, led_total = 0, led_run = 0, led_last = 0;
  int rx_falls = 0, rx_run = 0, rx_last = 0;

  always #10 clk = ~clk;

  ir_pulse_shaper #(.TX_PULSE_CLKS(TXP), .RX_BIT_CLKS(RXB)) u_ir_pulse_shaper (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .uart_txd(uart_txd),
    .bit_tick(bit_tick), .ir_rxd_n(ir_rxd_n), .ir_led(ir_led), .uart_rxd(uart_rxd)
  );

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (ir_led) begin
      if (led_run == 0) led_pulses++;
      led_run++;
      led_total++;
    end else if (led_run != 0) begin
      led_last = led_run;
      led_run  = 0;
    end
    if (!uart_rxd) begin
      if (rx_run == 0) rx_falls++;
      rx_run++;
    end else if (rx_run != 0) begin
      rx_last = rx_run;
      rx_run  = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] data);
    logic [9:0] bits;
    bits = {1'b1, data, 1'b0};
    for (int b = 0; b < 10; b++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0; uart_txd = bits[b];
      cycles(BIT - 2);
    end
    cycles(BIT);
  endtask

  task automatic t_reset_state();
    check(ir_led == 1'b0, "R1 led during reset", ir_led, 0);
    check(uart_rxd == 1'b1, "R1 rxd during reset", uart_rxd, 1);
    @(negedge clk); rst = 1'b0;
    cycles(4);
  endtask

  task automatic t_single_pulse();
    int p0;
    p0 = led_pulses;
    uart_txd = 1'b0;
    @(negedge clk);
    check(ir_led == 1'b1, "R2 led on next edge", ir_led, 1);
    cycles(TXP + 4);
    uart_txd = 1'b1;
    cycles(4);
    check(led_pulses - p0 == 1, "R2 one pulse", led_pulses - p0, 1);
    check(led_last == TXP, "R2 pulse width", led_last, TXP);
  endtask

  task automatic t_idle_ticks();
    int p0;
    p0 = led_pulses;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      cycles(BIT - 2);
    end
    check(led_pulses == p0, "R3 idle line no pulse", led_pulses - p0, 0);
  endtask

  task automatic t_frame(input logic [7:0] data, input int zeros);
    int p0, t0;
    p0 = led_pulses; t0 = led_total;
    send_frame(data);
    check(led_pulses - p0 == zeros, "R4 pulses per frame", led_pulses - p0, zeros);
    check(led_total - t0 == zeros * TXP, "R4 total on time", led_total - t0, zeros * TXP);
  endtask

  task automatic t_rx_basic(input int width);
    int lat;
    lat = 0;
    @(negedge clk); ir_rxd_n = 1'b0;
    for (int i = 0; i < 8 && uart_rxd; i++) begin
      @(negedge clk); lat++;
      if (lat == width) ir_rxd_n = 1'b1;
    end
    check(lat == 3, "R5 stretch latency", lat, 3);
    for (int i = lat; i < width; i++) @(negedge clk);
    ir_rxd_n = 1'b1;
    cycles(RXB + width + 4);
    check(rx_last == RXB, "R6 stretched width", rx_last, RXB);
  endtask

  task automatic t_rx_restart();
    int f0;
    f0 = rx_falls;
    @(negedge clk); ir_rxd_n = 1'b0;
    cycles(2); ir_rxd_n = 1'b1;
    cycles(6); ir_rxd_n = 1'b0;
    cycles(2); ir_rxd_n = 1'b1;
    cycles(2 * RXB + 8);
    check(rx_falls - f0 == 1, "R7 one merged low run", rx_falls - f0, 1);
    check(rx_last == 8 + RXB, "R7 window restarted", rx_last, 8 + RXB);
  endtask

  task automatic t_release_low();
    int p0, f0;
    p0 = led_pulses; f0 = rx_falls;
    @(negedge clk); soft_rst = 1'b1;
    uart_txd = 1'b0; ir_rxd_n = 1'b0;
    cycles(3);
    check(uart_rxd == 1'b1, "R1 rxd high in soft reset", uart_rxd, 1);
    check(ir_led == 1'b0, "R1 led off in soft reset", ir_led, 0);
    soft_rst = 1'b0;
    cycles(RXB + 6);
    check(led_pulses == p0, "R8 no tx pulse after release", led_pulses - p0, 0);
    check(rx_falls == f0, "R8 no rx stretch after release", rx_falls - f0, 0);
    uart_txd = 1'b1; ir_rxd_n = 1'b1;
    cycles(4);
  endtask

  task automatic t_soft_cut();
    uart_txd = 1'b0;
    cycles(2);
    check(ir_led == 1'b1, "R9 pulse running", ir_led, 1);
    soft_rst = 1'b1;
    @(negedge clk);
    check(ir_led == 1'b0, "R9 soft reset cuts pulse", ir_led, 0);
    soft_rst = 1'b0; uart_txd = 1'b1;
    cycles(TXP + 4);
    check(ir_led == 1'b0, "R9 stays off", ir_led, 0);
  endtask

  initial begin
    cycles(3);
    t_reset_state();
    t_single_pulse();
    t_idle_ticks();
    t_frame(8'h00, 9);
    t_frame(8'h55, 5);
    t_frame(8'hFF, 1);
    t_rx_basic(2);
    t_rx_basic(RXB + 10);
    t_rx_restart();
    t_release_low();
    t_soft_cut();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule